// File: doc/BRIEF.md
# Presettable Binary Counter Stage

A synchronous up-counter slice built to be chained into wider counters. On each rising clock edge it can take a parallel data word, advance by one, or keep its value. Which of the three happens depends only on the control levels present at that edge. An active-low clear drives the count to zero at once, without waiting for the clock. Inside the block the clear is released in step with the clock, so a release close to an edge cannot leave the count in a half-updated state.

Two enables gate counting: a parallel enable and a trickle enable. Both must be high for the count to advance. Only the trickle enable feeds the carry output. The carry is the look-ahead term: it is high while the count holds its all-ones value and the trickle enable is high. Wiring the carry of one stage to the trickle enable of the next builds an n-bit synchronous counter with no extra gating. The parallel enables of all stages can then be driven together as a common count strobe.

Top module: `pcs_counter_stage`

## Requirements
- R1: The count changes only at a rising clock edge. When load or an enable changes between edges, the count does not move until the next edge.
- R2: While the active-low clear is low, the count is zero at once, before any clock edge and whatever the load and enable levels. The carry is low during that time.
- R3: After the clear rises, the count stays zero through the next two rising edges. The third rising edge is the first one that can load or count.
- R4: A rising edge with load low copies the data word into the count, whatever the levels of both enables.
- R5: A rising edge with load high and both enables high adds one to the count.
- R6: A rising edge with load high and either enable low leaves the count unchanged. The data word is ignored.
- R7: Counting up from the all-ones value (15) gives zero. The count does not saturate.
- R8: The carry equals the trickle enable ANDed with every count bit. It follows the trickle enable combinationally, without a clock edge.
- R9: The parallel enable has no effect on the carry.
- R10: After a clear, loading 12 and then counting gives 13, 14, 15, 0, 1, 2. After that the count holds while either enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all count bits update on its rising edge |
| clr_n | input | 1 | Active-low clear, asserts asynchronously |
| load_n | input | 1 | Active-low synchronous parallel load |
| din | input | WIDTH (4) | Parallel data word |
| en_par | input | 1 | Parallel count enable |
| en_trk | input | 1 | Trickle count enable; also gates the carry |
| count | output | WIDTH (4) | Current count |
| carry | output | 1 | Look-ahead carry: en_trk AND all count bits |

## Verification
The stimulus table drives load, count and hold edges in mixed order. It starts with the preset-to-12 sequence that crosses the 15-to-0 wrap. Then it loads with both enables high, which separates load priority from counting. It holds once with each enable low in turn, which separates the two enables. At the all-ones value, the trickle enable and the parallel enable are toggled between edges. This shows that only the trickle enable reaches the carry, and that it does so without a clock edge. Directed tests apply a clear in the middle of a cycle and release it, which separates the asynchronous assertion from the clocked two-edge release.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    // Operation chosen for the next rising edge, in priority order.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2
    } pcs_op_e;

    localparam int unsigned PCS_SYNC_STAGES_DEF = 2;

endpackage

// File: rtl/pcs_clr_sync.sv
// Clear conditioner: asserts together with the pin, releases after STAGES edges.
module pcs_clr_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic clr_n,
    output logic clr_int_n
);
    localparam int unsigned LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d = sync_q;
        sync_d.chain[0] = 1'b1;
        for (int i = 1; i < STAGES; i++) begin
            sync_d.chain[i] = sync_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign clr_int_n = sync_q.chain[LAST];

endmodule

// File: rtl/pcs_mode_dec.sv
// Priority decode of the control pins: load wins over both enables.
module pcs_mode_dec
    import pcs_pkg::*;
(
    input  logic    load_n,
    input  logic    en_par,
    input  logic    en_trk,
    output pcs_op_e op
);
    always_comb begin
        if (!load_n) begin
            op = OP_LOAD;
        end else if (en_par && en_trk) begin
            op = OP_COUNT;
        end else begin
            op = OP_HOLD;
        end
    end
endmodule

// File: rtl/pcs_carry_chain.sv
// Look-ahead terms: toggle enables for each bit and the gated carry out.
module pcs_carry_chain #(
    parameter int unsigned WIDTH = 4
) (
    input  logic [WIDTH-1:0] cnt,
    input  logic             en_trk,
    output logic [WIDTH-1:0] tgl,
    output logic             carry
);
    logic [WIDTH:0] ones_pre;
    logic [WIDTH:0] trk_pre;

    assign ones_pre[0] = 1'b1;
    assign trk_pre[0]  = en_trk;

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        assign tgl[g]        = ones_pre[g];
        assign ones_pre[g+1] = ones_pre[g] & cnt[g];
        assign trk_pre[g+1]  = trk_pre[g] & cnt[g];
    end

    assign carry = trk_pre[WIDTH];

endmodule

// File: rtl/pcs_counter_stage.sv
module pcs_counter_stage
    import pcs_pkg::*;
#(
    parameter int unsigned WIDTH       = 4,
    parameter int unsigned SYNC_STAGES = PCS_SYNC_STAGES_DEF
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic [WIDTH-1:0] din,
    input  logic             en_par,
    input  logic             en_trk,
    output logic [WIDTH-1:0] count,
    output logic             carry
);
    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } stage_t;

    stage_t           st_d, st_q;
    pcs_op_e          op;
    logic [WIDTH-1:0] tgl;
    logic             clr_int_n;

    pcs_clr_sync #(.STAGES(SYNC_STAGES)) u_clr (
        .clk       (clk),
        .clr_n     (clr_n),
        .clr_int_n (clr_int_n)
    );

    pcs_mode_dec u_dec (
        .load_n (load_n),
        .en_par (en_par),
        .en_trk (en_trk),
        .op     (op)
    );

    pcs_carry_chain #(.WIDTH(WIDTH)) u_chain (
        .cnt    (st_q.cnt),
        .en_trk (en_trk),
        .tgl    (tgl),
        .carry  (carry)
    );

    always_comb begin
        st_d = st_q;
        case (op)
            OP_LOAD:  st_d.cnt = din;
            OP_COUNT: st_d.cnt = st_q.cnt ^ tgl;
            default:  st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge clr_int_n) begin
        if (!clr_int_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;

endmodule

// File: rtl/pcs_checker.sv
module pcs_checker #(
    parameter int unsigned WIDTH = 4
) (
    input logic             clk,
    input logic             clr_n,
    input logic             clr_int_n,
    input logic             load_n,
    input logic [WIDTH-1:0] din,
    input logic             en_par,
    input logic             en_trk,
    input logic [WIDTH-1:0] count,
    input logic             carry
);
    // R2
    clear_zero_chk: assert property (@(posedge clk)
        !clr_n |-> (count == '0 && !carry));

    // R3
    release_zero_chk: assert property (@(posedge clk) disable iff (!clr_n)
        $rose(clr_int_n) |-> count == '0);

    // R4
    load_take_chk: assert property (@(posedge clk) disable iff (!clr_int_n)
        !load_n |=> count == $past(din));

    // R5
    count_step_chk: assert property (@(posedge clk) disable iff (!clr_int_n)
        (load_n && en_par && en_trk) |=> count == WIDTH'($past(count) + 1'b1));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!clr_int_n)
        (load_n && !(en_par && en_trk)) |=> $stable(count));

    // R8
    carry_max_chk: assert property (@(posedge clk) disable iff (!clr_n)
        carry |-> (en_trk && count == {WIDTH{1'b1}}));

    // R9
    carry_par_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (en_trk && count == {WIDTH{1'b1}}) |-> carry);
endmodule

bind pcs_counter_stage pcs_checker #(.WIDTH(WIDTH)) u_pcs_chk (
    .clk       (clk),
    .clr_n     (clr_n),
    .clr_int_n (clr_int_n),
    .load_n    (load_n),
    .din       (din),
    .en_par    (en_par),
    .en_trk    (en_trk),
    .count     (count),
    .carry     (carry)
);

// File: tb/tb_pcs_counter_stage.sv
module tb_pcs_counter_stage;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         clr_n, load_n, en_par, en_trk;
    logic [W-1:0] din;
    logic [W-1:0] count;
    logic         carry;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    pcs_counter_stage #(.WIDTH(W)) dut (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
        .en_par(en_par), .en_trk(en_trk), .count(count), .carry(carry)
    );

    always #5 clk = ~clk;

    // kind: 0 load (R4), 1 count (R5), 2 hold (R6)
    typedef struct packed {
        logic         ld_n;
        logic         p;
        logic         t;
        logic [W-1:0] d;
        logic [W-1:0] q;
        logic         c;
        logic [1:0]   kind;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 1'b0, 4'd12, 4'd12, 1'b0, 2'd0},
        '{1'b1, 1'b1, 1'b1, 4'd0,  4'd13, 1'b0, 2'd1},
        '{1'b1, 1'b1, 1'b1, 4'd0,  4'd14, 1'b0, 2'd1},
        '{1'b1, 1'b1, 1'b1, 4'd0,  4'd15, 1'b1, 2'd1},
        '{1'b1, 1'b1, 1'b1, 4'd0,  4'd0,  1'b0, 2'd1},
        '{1'b1, 1'b1, 1'b1, 4'd0,  4'd1,  1'b0, 2'd1},
        '{1'b1, 1'b1, 1'b1, 4'd0,  4'd2,  1'b0, 2'd1},
        '{1'b1, 1'b0, 1'b1, 4'd9,  4'd2,  1'b0, 2'd2},
        '{1'b1, 1'b1, 1'b0, 4'd0,  4'd2,  1'b0, 2'd2},
        '{1'b0, 1'b1, 1'b1, 4'd15, 4'd15, 1'b1, 2'd0},
        '{1'b1, 1'b1, 1'b0, 4'd0,  4'd15, 1'b0, 2'd2},
        '{1'b1, 1'b0, 1'b1, 4'd0,  4'd15, 1'b1, 2'd2},
        '{1'b0, 1'b0, 1'b0, 4'd7,  4'd7,  1'b0, 2'd0},
        '{1'b1, 1'b1, 1'b1, 4'd0,  4'd8,  1'b0, 2'd1},
        '{1'b0, 1'b1, 1'b0, 4'd0,  4'd0,  1'b0, 2'd0}
    };

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic edge_sample();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seq_bad;
        clr_n = 1'b0; load_n = 1'b1; en_par = 1'b1; en_trk = 1'b1; din = '0;
        repeat (3) @(negedge clk);
        // R2: reset state even with both enables high
        check("R2 reset count", count, 0);
        check("R2 reset carry", carry, 0);

        // R3: release, then two held edges, load on the third
        clr_n = 1'b1; load_n = 1'b0; din = 4'd5;
        edge_sample(); check("R3 edge1", count, 0);
        edge_sample(); check("R3 edge2", count, 0);
        edge_sample(); check("R3 edge3 load", count, 5);

        // R10 starts from a clear
        @(negedge clk); clr_n = 1'b0;
        @(negedge clk); clr_n = 1'b1; load_n = 1'b1; en_par = 1'b0; en_trk = 1'b0;
        edge_sample(); edge_sample();

        seq_bad = 0;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            load_n = VEC[i].ld_n; en_par = VEC[i].p; en_trk = VEC[i].t; din = VEC[i].d;
            edge_sample();
            if (i <= 8 && count != VEC[i].q) seq_bad++;
            case (VEC[i].kind)
                2'd0:    check("R4 load", count, VEC[i].q);
                2'd1:    check("R5 count", count, VEC[i].q);
                default: check("R6 hold", count, VEC[i].q);
            endcase
            check("R8 carry", carry, VEC[i].c);
        end
        check("R10 sequence mismatches", seq_bad, 0);

        // R1: control change between edges does not move the count
        @(negedge clk); load_n = 1'b0; din = 4'd9; en_par = 1'b1; en_trk = 1'b1;
        #2; check("R1 no change before edge", count, 0);
        edge_sample(); check("R4 load after edge", count, 9);

        // R7: wrap
        @(negedge clk); load_n = 1'b0; din = 4'd15;
        edge_sample(); check("R7 preset max", count, 15);
        @(negedge clk); load_n = 1'b1;
        edge_sample(); check("R7 wrap", count, 0); check("R7 carry after wrap", carry, 0);

        // R8 / R9: carry between edges
        @(negedge clk); load_n = 1'b0; din = 4'd15; en_trk = 1'b0; en_par = 1'b0;
        edge_sample(); check("R8 max trk low", carry, 0);
        @(negedge clk); load_n = 1'b1; en_par = 1'b0; en_trk = 1'b1;
        #1; check("R8 trk rise no edge", carry, 1);
        en_trk = 1'b0;
        #1; check("R8 trk fall no edge", carry, 0);
        en_trk = 1'b1; en_par = 1'b1;
        #1; check("R9 par high", carry, 1);
        en_par = 1'b0;
        #1; check("R9 par low", carry, 1);
        edge_sample(); check("R6 hold at max", count, 15);

        // R2: clear in mid-cycle
        #2; clr_n = 1'b0;
        #1; check("R2 async count", count, 0); check("R2 async carry", carry, 0);
        @(negedge clk); clr_n = 1'b1;
        repeat (3) edge_sample();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule